// File: doc/BRIEF.md
# Radar Return Averaging Unit

This block sits between a tracking radar interface and the downstream fire-control arithmetic. Once per millisecond the radar side pulses a sample tick and presents five unsigned 14-bit words: range, bearing, elevation, and the sine and cosine of bearing. A single flag on the same tick says whether the return is meaningful. Up to one return in three may be unusable.

The unit counts ticks in fixed windows of four. Some returns in a window may be flagged as unusable. For each such return, each parameter is replaced by the last good value seen for that parameter. The four resulting values are summed and divided by four, rounding down. At the close of every window the five averages are loaded into registered outputs. An update strobe is raised for one clock, so with a 1 kHz tick the unit delivers 250 updates per second. Range, bearing and elevation are the primary results. Sine and cosine appear on secondary outputs with identical treatment.

Top module: `radar_avg_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, the update strobe is low and all five outputs read 0.
- R2: Input words and the valid flag are sampled only on clock edges where the tick is high. Changes on any other cycle affect neither the outputs nor later averages.
- R3: Ticks are grouped in fours, counted from reset; the first window is ticks 1 to 4. The strobe is high for exactly one clock, in the cycle right after the clock edge that captures the fourth tick of a window, and is low at all other times.
- R4: At the end of a window, each output equals floor(sum/4) of its four filled values. The sum is 16 bits wide and cannot overflow, so four samples of 16383 average to 16383.
- R5: On a tick whose valid flag is low, each parameter uses the last value captured with the flag high. That held value changes only on a valid tick.
- R6: Before the first valid return after reset, the held value of every parameter is 0. A window end with no valid return since reset loads the outputs but leaves the strobe low.
- R7: The outputs change only at window ends and hold their values between them.
- R8: Sine and cosine of bearing are filled, summed and averaged exactly like range, and appear on their own outputs.
- R9: The window position depends only on the tick count, never on the valid flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-clock sample pulse, one per radar return |
| ret_ok_i | input | 1 | High when this return is meaningful |
| range_i | input | 14 | Range sample |
| bearing_i | input | 14 | Bearing sample |
| elev_i | input | 14 | Elevation sample |
| sin_i | input | 14 | Sine of bearing sample |
| cos_i | input | 14 | Cosine of bearing sample |
| upd_o | output | 1 | One-clock strobe marking a new averaged update |
| range_o | output | 14 | Averaged range |
| bearing_o | output | 14 | Averaged bearing |
| elev_o | output | 14 | Averaged elevation |
| sin_o | output | 14 | Averaged sine of bearing |
| cos_o | output | 14 | Averaged cosine of bearing |

## Verification
A slipped window counter moves the strobe off the fourth-tick boundary. This shows up at the first window end after the fault, within four ticks. A corrupted hold register only shows when an invalid return needs filling. The wrong average then appears at the end of that window. An accumulator that is not cleared at the start of a window shows up immediately: the next update is too large.

// File: rtl/radar_avg_pkg.sv
package radar_avg_pkg;

  // Fixed set of per-return parameters carried by each tick
  localparam int unsigned NUM_PARAMS = 5;

  typedef enum int unsigned {
    IDX_RANGE   = 0,
    IDX_BEARING = 1,
    IDX_ELEV    = 2,
    IDX_SIN     = 3,
    IDX_COS     = 4
  } param_idx_e;

endpackage

// File: rtl/avg_window_ctrl.sv
module avg_window_ctrl #(
  parameter int unsigned WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic ret_ok_i,
  output logic first_o,
  output logic last_o,
  output logic upd_o
);

  localparam int unsigned CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [CW-1:0] cnt_q;
  logic          seen_q;
  logic          upd_q;

  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == LAST);
  assign upd_o   = upd_q;

  // Window position advances on every tick, whatever the valid flag
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      if (tick_i && ret_ok_i) seen_q <= 1'b1;
      upd_q <= tick_i && last_o && (seen_q || ret_ok_i);
    end
  end

  // R9: the counter stays inside the window
  a_r9_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R3: the strobe lasts a single clock
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
    upd_q |=> !upd_q);

  // R2: a strobe always follows a captured tick
  a_r2_strobe_after_tick: assert property (@(posedge clk) disable iff (rst)
    upd_q |-> $past(tick_i));

  // R6: no strobe without a valid return since reset
  a_r6_strobe_needs_valid: assert property (@(posedge clk) disable iff (rst)
    upd_q |-> seen_q);

endmodule

// File: rtl/avg_lane.sv
module avg_lane #(
  parameter int unsigned W   = 14,
  parameter int unsigned WIN = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         ret_ok_i,
  input  logic         first_i,
  input  logic         last_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] avg_o
);

  localparam int unsigned SHIFT = $clog2(WIN);
  localparam int unsigned ACCW  = W + SHIFT;

  logic [W-1:0]    hold_q;
  logic [ACCW-1:0] acc_q;
  logic [W-1:0]    avg_q;
  logic [W-1:0]    fill;
  logic [ACCW-1:0] acc_nxt;
  logic [ACCW-1:0] acc_shr;

  // Missing returns take the last good value for this parameter
  assign fill    = ret_ok_i ? din_i : hold_q;
  assign acc_nxt = (first_i ? '0 : acc_q) + ACCW'(fill);
  assign acc_shr = acc_nxt >> SHIFT;
  assign avg_o   = avg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      acc_q  <= '0;
      avg_q  <= '0;
    end else if (tick_i) begin
      if (ret_ok_i) hold_q <= din_i;
      acc_q <= acc_nxt;
      if (last_i) avg_q <= acc_shr[W-1:0];
    end
  end

  // R5: the held value moves only on a valid tick
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !(tick_i && ret_ok_i) |=> $stable(hold_q));

  // R7: the output moves only at a window end
  a_r7_avg_hold: assert property (@(posedge clk) disable iff (rst)
    !(tick_i && last_i) |=> $stable(avg_q));

  // R4: the accumulator never wraps within a window
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !first_i) |-> (acc_nxt >= acc_q));

endmodule

// File: rtl/radar_avg_unit.sv
module radar_avg_unit #(
  parameter int unsigned W   = 14,
  parameter int unsigned WIN = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         ret_ok_i,
  input  logic [W-1:0] range_i,
  input  logic [W-1:0] bearing_i,
  input  logic [W-1:0] elev_i,
  input  logic [W-1:0] sin_i,
  input  logic [W-1:0] cos_i,
  output logic         upd_o,
  output logic [W-1:0] range_o,
  output logic [W-1:0] bearing_o,
  output logic [W-1:0] elev_o,
  output logic [W-1:0] sin_o,
  output logic [W-1:0] cos_o
);

  import radar_avg_pkg::*;

  logic [W-1:0] din  [NUM_PARAMS];
  logic [W-1:0] dout [NUM_PARAMS];
  logic         first_w;
  logic         last_w;

  assign din[IDX_RANGE]   = range_i;
  assign din[IDX_BEARING] = bearing_i;
  assign din[IDX_ELEV]    = elev_i;
  assign din[IDX_SIN]     = sin_i;
  assign din[IDX_COS]     = cos_i;

  avg_window_ctrl #(.WIN(WIN)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .ret_ok_i (ret_ok_i),
    .first_o  (first_w),
    .last_o   (last_w),
    .upd_o    (upd_o)
  );

  for (genvar g = 0; g < NUM_PARAMS; g++) begin : g_lane
    avg_lane #(.W(W), .WIN(WIN)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .tick_i   (tick_i),
      .ret_ok_i (ret_ok_i),
      .first_i  (first_w),
      .last_i   (last_w),
      .din_i    (din[g]),
      .avg_o    (dout[g])
    );
  end

  assign range_o   = dout[IDX_RANGE];
  assign bearing_o = dout[IDX_BEARING];
  assign elev_o    = dout[IDX_ELEV];
  assign sin_o     = dout[IDX_SIN];
  assign cos_o     = dout[IDX_COS];

  // R1: outputs are quiet on the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!upd_o && range_o == '0 && cos_o == '0));

endmodule

// File: tb/sim_radar_avg_unit.sv
module sim_radar_avg_unit;

  localparam int W = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic ret_ok_i = 1'b0;
  logic [W-1:0] range_i = '0, bearing_i = '0, elev_i = '0, sin_i = '0, cos_i = '0;
  logic upd_o;
  logic [W-1:0] range_o, bearing_o, elev_o, sin_o, cos_o;

  always #2.5 clk = ~clk;

  radar_avg_unit u0 (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ret_ok_i(ret_ok_i),
    .range_i(range_i), .bearing_i(bearing_i), .elev_i(elev_i),
    .sin_i(sin_i), .cos_i(cos_i),
    .upd_o(upd_o), .range_o(range_o), .bearing_o(bearing_o),
    .elev_o(elev_o), .sin_o(sin_o), .cos_o(cos_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench model state
  int m_hold [5];
  int m_sum  [5];
  int m_out  [5];
  int m_cnt  = 0;
  bit m_seen = 0;
  bit m_upd  = 0;

  function automatic int avg_of(int s);
    return s / 4;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dut_out(int p);
    case (p)
      0: return int'(range_o);
      1: return int'(bearing_o);
      2: return int'(elev_o);
      3: return int'(sin_o);
      default: return int'(cos_o);
    endcase
  endfunction

  task automatic check_all(string req);
    chk({req, " strobe"}, int'(upd_o), int'(m_upd));
    for (int p = 0; p < 5; p++) chk({req, " value"}, dut_out(p), m_out[p]);
  endtask

  task automatic set_inputs(int v [5]);
    range_i = W'(v[0]); bearing_i = W'(v[1]); elev_i = W'(v[2]);
    sin_i = W'(v[3]); cos_i = W'(v[4]);
  endtask

  // One captured return, then model update and check (R3 R4 R5 R8 R9)
  task automatic do_tick(bit ok, int v [5]);
    @(negedge clk);
    tick_i = 1'b1; ret_ok_i = ok; set_inputs(v);
    for (int p = 0; p < 5; p++) begin
      int f;
      f = ok ? v[p] : m_hold[p];
      if (ok) m_hold[p] = v[p];
      m_sum[p] += f;
    end
    if (ok) m_seen = 1;
    m_upd = 0;
    if (m_cnt == 3) begin
      for (int p = 0; p < 5; p++) begin
        m_out[p] = avg_of(m_sum[p]);
        m_sum[p] = 0;
      end
      m_upd = m_seen;
    end
    m_cnt = (m_cnt + 1) % 4;
    @(posedge clk); #1;
    check_all("R3 R4 R5 R8 R9 tick");
    @(negedge clk);
    tick_i = 1'b0;
    m_upd = 0;
  endtask

  // Idle cycles with noisy inputs that must be ignored (R2 R7)
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      int v [5];
      @(negedge clk);
      tick_i = 1'b0;
      ret_ok_i = 1'($urandom_range(0, 1));
      for (int p = 0; p < 5; p++) v[p] = $urandom_range(0, 16383);
      set_inputs(v);
      @(posedge clk); #1;
      check_all("R2 R7 idle");
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v [5];
    void'($urandom(32'd1234));
    for (int p = 0; p < 5; p++) begin m_hold[p] = 0; m_sum[p] = 0; m_out[p] = 0; end
    repeat (4) @(posedge clk);
    #1;
    check_all("R1 in reset");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check_all("R1 after reset");

    // R6: a whole window of invalid returns, no strobe, outputs load 0
    for (int t = 0; t < 4; t++) begin
      for (int p = 0; p < 5; p++) v[p] = 1000 + 100 * p + t;
      do_tick(1'b0, v);
      idle(1);
    end

    // R4: maximum values do not overflow
    for (int t = 0; t < 4; t++) begin
      for (int p = 0; p < 5; p++) v[p] = 16383;
      do_tick(1'b1, v);
    end
    idle(2);

    // R5: invalid returns reuse last good values, distinct per lane (R8)
    for (int t = 0; t < 4; t++) begin
      for (int p = 0; p < 5; p++) v[p] = 40 * (p + 1) + 7 * t;
      do_tick(t[0] == 1'b0, v);
      idle(t);
    end

    // R9: a window ending in invalid returns still closes on the fourth tick
    for (int t = 0; t < 4; t++) begin
      for (int p = 0; p < 5; p++) v[p] = 9;
      do_tick(t == 0, v);
    end

    // Random traffic, about one return in three unusable
    for (int k = 0; k < 400; k++) begin
      for (int p = 0; p < 5; p++) v[p] = $urandom_range(0, 16383);
      do_tick($urandom_range(0, 2) != 0, v);
      idle($urandom_range(0, 3));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule